// File: doc/BRIEF.md
# Write-Combining Result Bit Merger

This block collects one-bit classification results from several sender channels that report under one shared routing ID. It packs them into a single payload word for a receiver. Each sender holds its own settings: an enable, an even bit position, a payload length in bytes, a combining duration and the value to drive on its valid bit. An accepted result puts a two-bit pair into the payload. The data bit sits at the sender's position and the valid bit one place above it. Every pair that arrives while the combining window is open is ORed into the same word.

The window opens on the first accepted result. It closes after the opener's duration, and the merged word then waits in a receive slot until the receiver pops it. A pop names an ID. If the ID matches the block's group ID and a word is waiting, the pop returns the word and frees the slot. Any other pop returns at once with an empty flag. A result with a bad placement is dropped and pulses an error flag. So is a result that arrives while the slot is still full.

The controller is a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Slot empty, no window open |
| `ST_GATHER` | Window open, pairs being merged |
| `ST_HELD` | Merged word waiting in the slot for a pop |

| Transition | From | To | Condition |
|---|---|---|---|
| open-short | `ST_IDLE` | `ST_HELD` | An accepted result arrives and the opener's duration is 0 or 1 |
| open-long | `ST_IDLE` | `ST_GATHER` | An accepted result arrives and the opener's duration is 2 or more |
| close | `ST_GATHER` | `ST_HELD` | The last cycle of the window |
| drain | `ST_HELD` | `ST_IDLE` | A pop with the matching ID |

Top module: `wcm_merge`

## Requirements
- R1: A settings write (`cfg_we` with `cfg_sel` naming the sender) takes effect for results from the next cycle on. After reset every sender is disabled.
- R2: An accepted result places the data bit at bit `pos` of the payload and the valid bit at bit `pos`+1. The valid bit is 1 by default. Every other bit of the payload is 0.
- R3: With the sender's valid value set to 0, the bit at `pos`+1 stays 0 while the data bit is still placed at `pos`.
- R4: Results from several senders in the same cycle are ORed into one payload, each at its own position. Senders at positions 0 and 2 that both report 1 give 0x0F.
- R5: The window opens on the first accepted result and covers max(duration,1) clock edges, counting the opening edge. Results on any of those edges are merged. When several senders open the window together, the lowest-indexed one sets the duration.
- R6: A result from an enabled sender is dropped, and `err_o` is high in the next cycle, if any of these holds: the position is odd, the length is 0, length×8 exceeds the payload width, or `pos`+1 ≥ length×8.
- R7: A result from a disabled sender is ignored. It leaves no payload and raises no error.
- R8: A result that arrives while a merged payload waits in the slot is dropped, and `err_o` is high in the next cycle.
- R9: `pop_ack` is high exactly one cycle after each `pop_req`. When `pop_id` equals `GROUP_ID` and a payload is waiting, the ack returns that payload with `pop_empty`=0 and frees the slot. Otherwise it returns `pop_empty`=1 with `pop_data`=0.
- R10: A pop with a non-matching ID leaves the waiting payload untouched, so a later matching pop still returns it.
- R11: After reset, `pop_ack` and `err_o` are 0 and the slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | SEL_W | Sender whose settings are written |
| cfg_en | input | 1 | Write-combine enable |
| cfg_pos | input | 10 | Data bit position (even) |
| cfg_len | input | 7 | Payload length in bytes |
| cfg_dur | input | 16 | Combining window in clock cycles |
| cfg_vld_val | input | 1 | Value driven on the valid bit |
| res_vld | input | N_SEND | Result strobe per sender |
| res_bit | input | N_SEND | Classified bit per sender |
| pop_req | input | 1 | Pop request |
| pop_id | input | ID_W | ID addressed by the pop |
| pop_ack | output | 1 | Pop answered |
| pop_empty | output | 1 | Pop found no payload |
| pop_data | output | PAY_W | Popped payload |
| err_o | output | 1 | A result was dropped |

## Verification
The hardest case to reach is the edge of the combining window. A late result must land exactly on the last edge the window covers, and the next result must fall one edge later, after the payload has been committed. The directed tasks advance exactly one clock edge each. A sender with a duration of 4 opens the window, two idle edges follow, a second sender reports on the fourth edge, and a third sender reports on the fifth. The bench then expects the second sender's pair in the popped word, the third sender's pair absent, and an error pulse. A separate task makes two senders with different durations open the window together, which shows that the lower index sets the duration.

// File: rtl/wcm_pkg.sv
package wcm_pkg;
    localparam int POS_W = 10;
    localparam int LEN_W = 7;
    localparam int DUR_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_HELD   = 2'd2
    } wcm_state_t;

    typedef struct packed {
        logic             en;
        logic [POS_W-1:0] pos;
        logic [LEN_W-1:0] len;
        logic [DUR_W-1:0] dur;
        logic             vval;
    } wcm_cfg_t;
endpackage

// File: rtl/wcm_cfg_bank.sv
module wcm_cfg_bank
    import wcm_pkg::*;
#(
    parameter int N_SEND = 4,
    localparam int SEL_W = (N_SEND > 1) ? $clog2(N_SEND) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  wcm_cfg_t                wr_cfg,
    output wcm_cfg_t [N_SEND-1:0]   cfg_q
);
    for (genvar g = 0; g < N_SEND; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '{en: 1'b0, pos: '0, len: LEN_W'(1), dur: DUR_W'(1), vval: 1'b1};
            end else if (wr_en && (32'(wr_sel) == g)) begin
                cfg_q[g] <= wr_cfg;
            end
        end
    end
endmodule

// File: rtl/wcm_lane.sv
module wcm_lane
    import wcm_pkg::*;
#(
    parameter int PAY_W = 32
) (
    input  wcm_cfg_t          cfg,
    input  logic              res_vld,
    input  logic              res_bit,
    output logic [PAY_W-1:0]  word,
    output logic              take,
    output logic              bad
);
    logic [LEN_W+2:0] lim_bits;
    logic             place_ok;

    always_comb begin
        lim_bits = {cfg.len, 3'b000};
        place_ok = !cfg.pos[0]
                && (cfg.len != '0)
                && (32'(lim_bits) <= PAY_W)
                && ((32'(cfg.pos) + 32'd1) < 32'(lim_bits));
        take = res_vld && cfg.en && place_ok;
        bad  = res_vld && cfg.en && !place_ok;
        word = take ? (PAY_W'({cfg.vval, res_bit}) << cfg.pos) : '0;
    end
endmodule

// File: rtl/wcm_merge.sv
module wcm_merge
    import wcm_pkg::*;
#(
    parameter int N_SEND    = 4,
    parameter int PAY_BYTES = 4,
    parameter int ID_W      = 5,
    parameter int GROUP_ID  = 16,
    localparam int PAY_W    = PAY_BYTES * 8,
    localparam int SEL_W    = (N_SEND > 1) ? $clog2(N_SEND) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_en,
    input  logic [9:0]        cfg_pos,
    input  logic [6:0]        cfg_len,
    input  logic [15:0]       cfg_dur,
    input  logic              cfg_vld_val,
    input  logic [N_SEND-1:0] res_vld,
    input  logic [N_SEND-1:0] res_bit,
    input  logic              pop_req,
    input  logic [ID_W-1:0]   pop_id,
    output logic              pop_ack,
    output logic              pop_empty,
    output logic [PAY_W-1:0]  pop_data,
    output logic              err_o
);
    wcm_cfg_t [N_SEND-1:0] cfgs;
    wcm_cfg_t              wr_cfg;
    logic [PAY_W-1:0]      lane_word [N_SEND];
    logic [N_SEND-1:0]     lane_take;
    logic [N_SEND-1:0]     lane_bad;
    logic [PAY_W-1:0]      contrib;
    logic [DUR_W-1:0]      open_dur;
    logic                  take_any;
    logic                  id_hit;
    wcm_state_t            st_q, st_d;
    logic [PAY_W-1:0]      acc_q;
    logic [DUR_W-1:0]      cnt_q;

    assign wr_cfg = '{en: cfg_en, pos: cfg_pos, len: cfg_len, dur: cfg_dur, vval: cfg_vld_val};

    wcm_cfg_bank #(.N_SEND(N_SEND)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_sel (cfg_sel),
        .wr_cfg (wr_cfg),
        .cfg_q  (cfgs)
    );

    for (genvar g = 0; g < N_SEND; g++) begin : g_lane
        wcm_lane #(.PAY_W(PAY_W)) i_lane (
            .cfg     (cfgs[g]),
            .res_vld (res_vld[g]),
            .res_bit (res_bit[g]),
            .word    (lane_word[g]),
            .take    (lane_take[g]),
            .bad     (lane_bad[g])
        );
    end

    always_comb begin
        contrib  = '0;
        open_dur = '0;
        for (int i = N_SEND - 1; i >= 0; i--) begin
            contrib = contrib | lane_word[i];
            if (lane_take[i]) open_dur = cfgs[i].dur;
        end
        take_any = |lane_take;
        id_hit   = pop_req && (32'(pop_id) == GROUP_ID);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (take_any) st_d = (open_dur <= DUR_W'(1)) ? ST_HELD : ST_GATHER;
            ST_GATHER: if (cnt_q <= DUR_W'(1)) st_d = ST_HELD;
            ST_HELD:   if (id_hit) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            pop_ack   <= 1'b0;
            pop_empty <= 1'b0;
            pop_data  <= '0;
            err_o     <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (take_any) begin
                    acc_q <= contrib;
                    cnt_q <= open_dur - DUR_W'(1);
                end
                ST_GATHER: begin
                    acc_q <= acc_q | contrib;
                    cnt_q <= cnt_q - DUR_W'(1);
                end
                ST_HELD: ;
                default: ;
            endcase
            pop_ack   <= pop_req;
            pop_empty <= pop_req && !(id_hit && st_q == ST_HELD);
            pop_data  <= (id_hit && st_q == ST_HELD) ? acc_q : '0;
            err_o     <= (|lane_bad) || (take_any && st_q == ST_HELD);
        end
    end
endmodule

// File: rtl/wcm_merge_chk.sv
module wcm_merge_chk
    import wcm_pkg::*;
#(
    parameter int N_SEND = 4,
    parameter int PAY_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pop_req,
    input logic              pop_ack,
    input logic              pop_empty,
    input logic [PAY_W-1:0]  pop_data,
    input logic [N_SEND-1:0] res_vld,
    input logic              err_o,
    input wcm_state_t        st_q
);
    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |=> pop_ack); // R9
    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> !pop_ack); // R9
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ack && pop_empty) |-> (pop_data == '0)); // R9
    AST_POP_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ack && !pop_empty) |-> (st_q != ST_HELD)); // R9
    AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld == '0) |=> !err_o); // R7
endmodule

bind wcm_merge wcm_merge_chk #(.N_SEND(N_SEND), .PAY_W(PAY_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_req   (pop_req),
    .pop_ack   (pop_ack),
    .pop_empty (pop_empty),
    .pop_data  (pop_data),
    .res_vld   (res_vld),
    .err_o     (err_o),
    .st_q      (st_q)
);

// File: tb/test_wcm_merge.sv
`timescale 1ns/100ps
module test_wcm_merge;
    localparam int N  = 4;
    localparam int PW = 32;
    localparam int GID = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic          cfg_en = 1'b0;
    logic [9:0]    cfg_pos = '0;
    logic [6:0]    cfg_len = '0;
    logic [15:0]   cfg_dur = '0;
    logic          cfg_vld_val = 1'b0;
    logic [N-1:0]  res_vld = '0;
    logic [N-1:0]  res_bit = '0;
    logic          pop_req = 1'b0;
    logic [4:0]    pop_id = '0;
    logic          pop_ack, pop_empty, err_o;
    logic [PW-1:0] pop_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wcm_merge #(.N_SEND(N), .PAY_BYTES(4), .ID_W(5), .GROUP_ID(GID)) i_wcm_merge (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_en, .cfg_pos, .cfg_len, .cfg_dur,
        .cfg_vld_val, .res_vld, .res_bit, .pop_req, .pop_id, .pop_ack,
        .pop_empty, .pop_data, .err_o
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // every task is entered at a negedge and consumes exactly one clock edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_cfg(input int sel, input logic en, input int pos, input int len,
                           input int dur, input logic vv);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_en = en; cfg_pos = 10'(pos);
        cfg_len = 7'(len); cfg_dur = 16'(dur); cfg_vld_val = vv;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [N-1:0] m, input logic [N-1:0] b, output logic e);
        res_vld = m; res_bit = b;
        @(negedge clk);
        e = err_o;
        res_vld = '0; res_bit = '0;
    endtask

    task automatic pop(input string req, input int id, input logic exp_empty,
                       input logic [31:0] exp_data);
        pop_req = 1'b1; pop_id = 5'(id);
        @(negedge clk);
        pop_req = 1'b0;
        check({req, " ack"}, 32'(pop_ack), 32'd1);
        check({req, " empty"}, 32'(pop_empty), 32'(exp_empty));
        check({req, " data"}, pop_data, exp_data);
    endtask

    task automatic t_reset_and_disabled();
        logic e;
        check("R11 ack after reset", 32'(pop_ack), 0);
        check("R11 err after reset", 32'(err_o), 0);
        send(4'b0001, 4'b0001, e);          // R1: senders disabled after reset
        check("R7 disabled no err", 32'(e), 0);
        pop("R11 slot empty", GID, 1'b1, 32'h0);
    endtask

    task automatic t_single();
        logic e;
        set_cfg(0, 1'b1, 0, 1, 1, 1'b1);
        send(4'b0001, 4'b0000, e);
        check("R1 no err", 32'(e), 0);
        pop("R2 single zero", GID, 1'b0, 32'h2);
        pop("R9 slot freed", GID, 1'b1, 32'h0);
    endtask

    task automatic t_two();
        logic e;
        set_cfg(0, 1'b1, 0, 1, 1, 1'b1);
        set_cfg(1, 1'b1, 2, 1, 1, 1'b1);
        send(4'b0011, 4'b0011, e);
        pop("R4 merged 0x0F", GID, 1'b0, 32'h0F);
    endtask

    task automatic t_override();
        logic e;
        set_cfg(2, 1'b1, 4, 1, 1, 1'b0);
        send(4'b0100, 4'b0100, e);
        pop("R3 valid override", GID, 1'b0, 32'h10);
        set_cfg(2, 1'b0, 4, 1, 1, 1'b1);
    endtask

    task automatic t_window();
        logic e;
        set_cfg(0, 1'b1, 0, 1, 4, 1'b1);
        set_cfg(1, 1'b1, 6, 1, 1, 1'b1);
        set_cfg(2, 1'b1, 2, 1, 1, 1'b1);
        send(4'b0001, 4'b0001, e);
        tick();
        tick();
        send(4'b0010, 4'b0000, e);          // last edge of the window
        check("R5 last edge accepted", 32'(e), 0);
        send(4'b0100, 4'b0100, e);          // one edge later: slot held
        check("R8 late drop err", 32'(e), 1);
        pop("R5 window merge", GID, 1'b0, 32'h83);
    endtask

    task automatic t_opener();
        logic e;
        set_cfg(0, 1'b1, 0, 1, 1, 1'b1);
        set_cfg(1, 1'b1, 2, 1, 8, 1'b1);
        set_cfg(2, 1'b1, 4, 1, 1, 1'b1);
        send(4'b0011, 4'b0011, e);
        send(4'b0100, 4'b0100, e);
        check("R5 lowest index sets duration", 32'(e), 1);
        pop("R5 opener payload", GID, 1'b0, 32'h0F);
    endtask

    task automatic t_bad();
        logic e;
        set_cfg(0, 1'b1, 8, 1, 1, 1'b1);
        send(4'b0001, 4'b0001, e);
        check("R6 beyond length err", 32'(e), 1);
        pop("R6 beyond length dropped", GID, 1'b1, 32'h0);
        set_cfg(0, 1'b1, 3, 1, 1, 1'b1);
        send(4'b0001, 4'b0001, e);
        check("R6 odd pos err", 32'(e), 1);
        set_cfg(0, 1'b1, 0, 5, 1, 1'b1);
        send(4'b0001, 4'b0001, e);
        check("R6 length too big err", 32'(e), 1);
        set_cfg(0, 1'b1, 0, 0, 1, 1'b1);
        send(4'b0001, 4'b0001, e);
        check("R6 zero length err", 32'(e), 1);
        pop("R6 nothing stored", GID, 1'b1, 32'h0);
        set_cfg(0, 1'b1, 8, 2, 1, 1'b1);
        send(4'b0001, 4'b0001, e);
        check("R6 two-byte ok", 32'(e), 0);
        pop("R6 two-byte payload", GID, 1'b0, 32'h300);
    endtask

    task automatic t_wrong_id();
        logic e;
        set_cfg(3, 1'b1, 30, 4, 1, 1'b1);
        send(4'b1000, 4'b1000, e);
        pop("R10 wrong id empty", GID + 1, 1'b1, 32'h0);
        pop("R10 payload kept", GID, 1'b0, 32'hC000_0000);
        set_cfg(3, 1'b0, 30, 4, 1, 1'b1);
        send(4'b1000, 4'b1000, e);
        check("R7 disabled again no err", 32'(e), 0);
        pop("R7 disabled no payload", GID, 1'b1, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_disabled();
        t_single();
        t_two();
        t_override();
        t_window();
        t_opener();
        t_bad();
        t_wrong_id();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule